// File: doc/BRIEF.md
# NAND Controller Interrupt Status Unit

This unit gathers the event lines of a NAND flash controller and presents them to software in two views. The first is a raw status word that tracks the present level of each source and carries a small corrected-error count. The second is a sticky word that remembers every rising edge of a source until software reads it. A per-source enable word selects which sticky flags may raise the level-high interrupt line. A device-ready output tells the host when both the flash device and the controller are idle.

The two words place the same sources at different bit positions, so software must decode each word against its own layout. Reading the sticky word returns its contents and empties it in the same access. An event that arrives during that read is kept for the next one. The raw word follows the source levels rather than the sticky flags. This matters because the ready level can still be low for a short time after its interrupt has fired.

Top module: `nand_irq_status`

## Requirements
- R1: The sticky word `irq_stat_o` and the enable word use this layout: bit 5 flash ready, bit 4 controller ready, bit 3 decode failure, bit 2 decode error, bit 1 ECC ready, bit 0 write-protect fault.
- R2: The raw word `raw_stat_o` shows each source level as it was sampled on the previous clock edge. Its layout is: bit 0 flash ready, bit 1 controller ready, bit 2 ECC ready, bit 3 errors detected (the decode-error source), bits [5:4] the count field, bit 6 decode failure.
- R3: The count field is the sampled `corr_cnt_i` minus one. A count of 0 gives 0, and a count of 4 or more saturates to 3.
- R4: A sticky flag sets on the clock edge where its source is high and was low on the previous edge. A source held high does not set its flag again after the flag has been cleared.
- R5: While `stat_rd_i` is high, `irq_stat_o` shows the flags. On that clock edge every flag clears unless R6 applies to it.
- R6: A rising edge that lands on the same clock edge as a clearing read leaves its flag set.
- R7: `irq_o` is high exactly while some sticky flag is set whose enable bit is 1.
- R8: When `mask_we_i` is high, the enable word loads `mask_wdata_i` on that edge, and `mask_o` shows it. The enable word has no effect on which flags set or clear.
- R9: `dev_ready_o` is high only when both the flash-ready and controller-ready raw bits are 1.
- R10: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| nand_rdy_i | input | 1 | Flash device ready level |
| ctl_rdy_i | input | 1 | Controller ready level |
| ecc_rdy_i | input | 1 | ECC result ready level |
| dec_err_i | input | 1 | Correctable decode error level |
| dec_fail_i | input | 1 | Uncorrectable decode failure level |
| wp_fault_i | input | 1 | Write-protect fault level |
| corr_cnt_i | input | 3 | Number of corrected errors |
| stat_rd_i | input | 1 | Read of the sticky word; clears it |
| mask_we_i | input | 1 | Enable word write strobe |
| mask_wdata_i | input | 6 | Enable word write data |
| irq_stat_o | output | 6 | Sticky status word |
| raw_stat_o | output | 7 | Raw status word |
| mask_o | output | 6 | Enable word readback |
| irq_o | output | 1 | Level-high interrupt |
| dev_ready_o | output | 1 | Device and controller both ready |

## Verification
The hardest case to reach from the ports is a source edge that lands on the very clock edge of a clearing read. The case that follows from it is a source that stays high after its flag is cleared and must not set the flag again. A directed sequence brings about both cases for several sources at once, with the enable word both open and closed. A long random phase then toggles sources, reads and enable writes densely enough to produce many more such collisions. In every cycle the design is compared against a behavioural model.

// File: rtl/nisu_pkg.sv
package nisu_pkg;
    localparam int NSRC    = 6;
    localparam int CNT_W   = 3;
    localparam int FIELD_W = 2;
    localparam int RAW_W   = NSRC + 1;

    // Sticky-word positions
    localparam int LB_WP   = 0;
    localparam int LB_ECC  = 1;
    localparam int LB_ERR  = 2;
    localparam int LB_FAIL = 3;
    localparam int LB_CTL  = 4;
    localparam int LB_NAND = 5;

    typedef struct packed {
        logic [NSRC-1:0]    src;
        logic [FIELD_W-1:0] cnt;
    } samp_t;

    typedef struct packed {
        logic [NSRC-1:0] lat;
        logic [NSRC-1:0] mask;
    } flag_t;
endpackage

// File: rtl/nisu_sampler.sv
module nisu_sampler
    import nisu_pkg::*;
#(
    parameter int N  = NSRC,
    parameter int CW = CNT_W,
    parameter int FW = FIELD_W
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [N-1:0]  src_i,
    input  logic [CW-1:0] cnt_i,
    output logic [N-1:0]  src_q_o,
    output logic [FW-1:0] cnt_q_o,
    output logic [N-1:0]  rise_o
);
    localparam int CNT_MAX = 2 ** FW;

    typedef struct packed {
        logic [N-1:0]  src;
        logic [FW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.src = src_i;
        if (cnt_i == '0)
            st_d.cnt = '0;
        else if (int'(cnt_i) >= CNT_MAX)
            st_d.cnt = '1;
        else
            st_d.cnt = FW'(cnt_i - CW'(1));
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    for (genvar i = 0; i < N; i++) begin : g_edge
        assign rise_o[i] = src_i[i] & ~st_q.src[i];
    end

    assign src_q_o = st_q.src;
    assign cnt_q_o = st_q.cnt;

    // R3: the count field never exceeds the input count
    assert_cnt_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (int'(cnt_q_o) <= int'($past(cnt_i))));
endmodule

// File: rtl/nisu_latch.sv
module nisu_latch
    import nisu_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] rise_i,
    input  logic         rd_i,
    input  logic         mask_we_i,
    input  logic [N-1:0] mask_wdata_i,
    output logic [N-1:0] lat_o,
    output logic [N-1:0] mask_o,
    output logic         irq_o
);
    typedef struct packed {
        logic [N-1:0] lat;
        logic [N-1:0] mask;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_i) st_d.lat = '0;
        st_d.lat = st_d.lat | rise_i;
        if (mask_we_i) st_d.mask = mask_wdata_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign lat_o  = st_q.lat;
    assign mask_o = st_q.mask;
    assign irq_o  = |(st_q.lat & st_q.mask);

    // R4 / R6: every edge leaves its flag set, read or not
    assert_edge_sets_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rise_i != '0) |=> ((lat_o & $past(rise_i)) == $past(rise_i)));

    // R5: a read with no coinciding edge empties the word
    assert_read_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && rise_i == '0) |=> (lat_o == '0));

    // R4: a flag only appears after an edge
    assert_no_spurious_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((lat_o & ~$past(lat_o) & ~$past(rise_i)) == '0));

    // R8: enable word loads on write, otherwise holds
    assert_mask_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mask_we_i |=> (mask_o == $past(mask_wdata_i)));
    assert_mask_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !mask_we_i |=> $stable(mask_o));
endmodule

// File: rtl/nand_irq_status.sv
module nand_irq_status
    import nisu_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               nand_rdy_i,
    input  logic               ctl_rdy_i,
    input  logic               ecc_rdy_i,
    input  logic               dec_err_i,
    input  logic               dec_fail_i,
    input  logic               wp_fault_i,
    input  logic [CNT_W-1:0]   corr_cnt_i,
    input  logic               stat_rd_i,
    input  logic               mask_we_i,
    input  logic [NSRC-1:0]    mask_wdata_i,
    output logic [NSRC-1:0]    irq_stat_o,
    output logic [RAW_W-1:0]   raw_stat_o,
    output logic [NSRC-1:0]    mask_o,
    output logic               irq_o,
    output logic               dev_ready_o
);
    logic [NSRC-1:0]    src_vec;
    logic [NSRC-1:0]    src_q;
    logic [NSRC-1:0]    rise;
    logic [FIELD_W-1:0] cnt_q;

    always_comb begin
        src_vec          = '0;
        src_vec[LB_WP]   = wp_fault_i;
        src_vec[LB_ECC]  = ecc_rdy_i;
        src_vec[LB_ERR]  = dec_err_i;
        src_vec[LB_FAIL] = dec_fail_i;
        src_vec[LB_CTL]  = ctl_rdy_i;
        src_vec[LB_NAND] = nand_rdy_i;
    end

    nisu_sampler #(.N(NSRC), .CW(CNT_W), .FW(FIELD_W)) u_samp (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .src_i   (src_vec),
        .cnt_i   (corr_cnt_i),
        .src_q_o (src_q),
        .cnt_q_o (cnt_q),
        .rise_o  (rise)
    );

    nisu_latch #(.N(NSRC)) u_lat (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .rise_i       (rise),
        .rd_i         (stat_rd_i),
        .mask_we_i    (mask_we_i),
        .mask_wdata_i (mask_wdata_i),
        .lat_o        (irq_stat_o),
        .mask_o       (mask_o),
        .irq_o        (irq_o)
    );

    // Raw word uses its own ordering
    assign raw_stat_o = {src_q[LB_FAIL], cnt_q, src_q[LB_ERR],
                         src_q[LB_ECC], src_q[LB_CTL], src_q[LB_NAND]};
    assign dev_ready_o = raw_stat_o[0] & raw_stat_o[1];

    // R2: raw bits follow the source levels one edge later
    assert_raw_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (raw_stat_o[0] == $past(nand_rdy_i) && raw_stat_o[1] == $past(ctl_rdy_i)
                  && raw_stat_o[6] == $past(dec_fail_i)));

    // R9: ready needs both sampled ready levels
    assert_ready_both_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (dev_ready_o == ($past(nand_rdy_i) && $past(ctl_rdy_i))));

    // R7: interrupt never raised with all enables closed
    assert_irq_masked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mask_o == '0) |-> !irq_o);
endmodule

// File: tb/nand_irq_status_bench.sv
module nand_irq_status_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic nand_rdy = 0, ctl_rdy = 0, ecc_rdy = 0, dec_err = 0, dec_fail = 0, wp_fault = 0;
    logic [2:0] corr_cnt = 0;
    logic stat_rd = 0, mask_we = 0;
    logic [5:0] mask_wdata = 0;
    logic [5:0] irq_stat, mask_rb;
    logic [6:0] raw_stat;
    logic irq, dev_ready;

    nand_irq_status u_nand_irq_status (
        .clk_i(clk), .rst_ni(rst_n),
        .nand_rdy_i(nand_rdy), .ctl_rdy_i(ctl_rdy), .ecc_rdy_i(ecc_rdy),
        .dec_err_i(dec_err), .dec_fail_i(dec_fail), .wp_fault_i(wp_fault),
        .corr_cnt_i(corr_cnt), .stat_rd_i(stat_rd), .mask_we_i(mask_we),
        .mask_wdata_i(mask_wdata), .irq_stat_o(irq_stat), .raw_stat_o(raw_stat),
        .mask_o(mask_rb), .irq_o(irq), .dev_ready_o(dev_ready)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // Reference model state
    int m_prev[6];
    int m_lat[6];
    int m_mask[6];
    int m_raw[7];

    function automatic int src_level(int idx);
        case (idx)
            0: return int'(wp_fault);
            1: return int'(ecc_rdy);
            2: return int'(dec_err);
            3: return int'(dec_fail);
            4: return int'(ctl_rdy);
            default: return int'(nand_rdy);
        endcase
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 6; i++) begin m_prev[i] = 0; m_lat[i] = 0; m_mask[i] = 0; end
        for (int i = 0; i < 7; i++) m_raw[i] = 0;
    endtask

    // Called at a rising edge, before inputs change
    task automatic model_step();
        int c;
        int f;
        for (int i = 0; i < 6; i++) begin
            int now = src_level(i);
            if (stat_rd) m_lat[i] = 0;
            if (now == 1 && m_prev[i] == 0) m_lat[i] = 1;
            if (mask_we) m_mask[i] = int'(mask_wdata[i]);
            m_prev[i] = now;
        end
        c = int'(corr_cnt);
        if (c == 0) f = 0; else if (c >= 4) f = 3; else f = c - 1;
        m_raw[0] = int'(nand_rdy);
        m_raw[1] = int'(ctl_rdy);
        m_raw[2] = int'(ecc_rdy);
        m_raw[3] = int'(dec_err);
        m_raw[4] = f % 2;
        m_raw[5] = f / 2;
        m_raw[6] = int'(dec_fail);
    endtask

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        int e_lat = 0, e_mask = 0, e_raw = 0, e_irq = 0;
        for (int i = 0; i < 6; i++) begin
            e_lat  += m_lat[i] << i;
            e_mask += m_mask[i] << i;
            if (m_lat[i] == 1 && m_mask[i] == 1) e_irq = 1;
        end
        for (int i = 0; i < 7; i++) e_raw += m_raw[i] << i;
        check("R1/R4/R5/R6 sticky word", int'(irq_stat), e_lat);
        check("R2 raw levels", int'(raw_stat) & 7'h4F, e_raw & 7'h4F);
        check("R3 count field", int'(raw_stat[5:4]), (e_raw >> 4) & 3);
        check("R7 interrupt", int'(irq), e_irq);
        check("R8 enable word", int'(mask_rb), e_mask);
        check("R9 device ready", int'(dev_ready), m_raw[0] * m_raw[1]);
    endtask

    // One clock: inputs already set; edge updates model; compare at negedge
    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic set_src(logic n, logic c, logic e, logic er, logic fl, logic wp);
        nand_rdy = n; ctl_rdy = c; ecc_rdy = e; dec_err = er; dec_fail = fl; wp_fault = wp;
    endtask

    initial begin
        #1600000;
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 reset sticky", int'(irq_stat), 0);
        check("R10 reset raw", int'(raw_stat), 0);
        check("R10 reset irq/ready/mask", int'({irq, dev_ready, mask_rb}), 0);
        rst_n = 1'b1;
        tick();

        // R1: each source alone lands in its sticky bit; enable all
        mask_we = 1; mask_wdata = 6'h3F; tick(); mask_we = 0;
        set_src(1,0,0,0,0,0); tick();
        set_src(1,1,0,0,0,0); tick();
        set_src(1,1,1,0,0,0); tick();
        set_src(1,1,1,1,0,0); corr_cnt = 3'd2; tick();
        set_src(1,1,1,1,1,0); corr_cnt = 3'd6; tick();  // R3 saturation
        set_src(1,1,1,1,1,1); corr_cnt = 3'd4; tick();
        // R5: read clears; R4: held levels do not set again
        stat_rd = 1; tick(); stat_rd = 0; tick(); tick();
        // R6: edge on the same edge as a read
        set_src(0,0,0,0,0,0); corr_cnt = 0; tick();
        set_src(1,0,1,0,1,0); stat_rd = 1; tick(); stat_rd = 0; tick();
        // R8: enables closed; flags still record, irq low
        mask_we = 1; mask_wdata = 6'h00; tick(); mask_we = 0;
        set_src(1,1,0,1,1,1); corr_cnt = 3'd1; tick(); tick();
        mask_we = 1; mask_wdata = 6'h10; tick(); mask_we = 0; tick();
        stat_rd = 1; tick(); stat_rd = 0; tick();

        // Random phase
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] r = $urandom;
            if (r[1:0] == 0) nand_rdy = ~nand_rdy;
            if (r[3:2] == 0) ctl_rdy  = ~ctl_rdy;
            if (r[5:4] == 0) ecc_rdy  = ~ecc_rdy;
            if (r[7:6] == 0) dec_err  = ~dec_err;
            if (r[9:8] == 0) dec_fail = ~dec_fail;
            if (r[11:10] == 0) wp_fault = ~wp_fault;
            corr_cnt   = r[14:12];
            stat_rd    = (r[16:15] == 0);
            mask_we    = (r[20:17] == 0);
            mask_wdata = r[26:21];
            tick();
        end

        // Reset mid-run returns outputs to zero
        rst_n = 0; model_reset(); @(posedge clk); @(negedge clk);
        check("R10 reset after activity", int'({irq_stat, raw_stat, mask_rb, irq, dev_ready}), 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule